// File: doc/BRIEF.md
# External Bus Read-Cycle Sequencer

This block runs single read cycles on an asynchronous external memory port. A requester presents a 22-bit address, a 3-bit space code and a waitstate count. The block then drives an active-low select line for the chosen space and puts the address on the bus. It pulls the active-low read strobe low, holds it for the programmed length plus any extension that the external acknowledge asks for, and samples the 16-bit data bus as the strobe rises. The captured word comes back with a one-tick done pulse.

The block runs on a clock at twice the peripheral rate, so one tick is half a peripheral period and every edge offset is a whole number of ticks. The select and address lead the strobe by one tick and trail it by one tick. A `busy` output holds off new requests until the cycle, its trailing edge and its recovery time are over.

Top module: `ext_rd_seq`

## Requirements
- R1: After synchronous reset, all select lines are high, the read strobe is high, the address bus is zero, `busy` is low and `rsp_valid` is low.
- R2: The space code picks the select line. Codes 0 to 3 drive `bus_sel_n` bits 0 to 3 (memory banks), code 4 drives bit 4 (I/O space) and code 5 drives bit 5 (boot space). At most one select line is ever low, and during a cycle exactly one is low.
- R3: The select line and the request address are on the bus one tick before the read strobe falls.
- R4: With acknowledge high, the strobe stays low for 2*(W+1) ticks, where W is `wait_cnt` sampled in the tick the request is accepted. Later changes to `wait_cnt` have no effect on a cycle already running.
- R5: Acknowledge is sampled at each point where the strobe could end. If it is low there, the strobe stays low for 2 more ticks, and this repeats until acknowledge is seen high.
- R6: `bus_data_in` is captured at the clock edge where the strobe rises. `rsp_valid` is high for exactly that one tick, with `rsp_data` holding the captured word, and is low at all other times.
- R7: The select line and the address stay driven for one tick after the strobe rises. After that, all selects are high and the address bus returns to zero.
- R8: The strobe stays high for at least 2 ticks between the end of one strobe and the start of the next.
- R9: `busy` is high from the tick after acceptance until the trailing tick is over. A request presented while `busy` is high is ignored and starts no cycle.
- R10: A request with space code 6 or 7 is ignored. No select falls, no strobe falls and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the peripheral rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 22 | Read address |
| req_space | input | 3 | Space code (0-3 banks, 4 I/O, 5 boot) |
| wait_cnt | input | 4 | Programmed waitstates in peripheral periods |
| busy | output | 1 | Cycle in progress; requests are not taken |
| bus_sel_n | output | 6 | Active-low space selects |
| bus_addr | output | 22 | External address bus |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_data_in | input | 16 | External data bus |
| bus_ack | input | 1 | External acknowledge, high = ready |
| rsp_valid | output | 1 | One-tick done pulse |
| rsp_data | output | 16 | Captured read data |

## Verification
The bench builds the block with its default parameters: a 22-bit address, 16-bit data and a 4-bit waitstate field. With these values W runs from zero, which gives the shortest 2-tick strobe, up to 15, which gives a 32-tick strobe. Acknowledge delays that fall between boundaries or past the programmed count bring the rounding of the extension to whole peripheral periods within reach. All six select codes and both unused codes are used, and a back-to-back pair of cycles exposes the recovery gap.

// File: rtl/ext_rd_pkg.sv
package ext_rd_pkg;
  localparam int SPACE_W = 3;
  localparam int NUM_SEL = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } rd_state_e;
endpackage

// File: rtl/ext_rd_space_dec.sv
module ext_rd_space_dec #(
  parameter int SPACE_W = 3,
  parameter int NUM_SEL = 6
) (
  input  logic [SPACE_W-1:0] space,
  output logic [NUM_SEL-1:0] onehot,
  output logic               valid
);
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    assign onehot[i] = (space == SPACE_W'(i));
  end
  assign valid = |onehot;
endmodule

// File: rtl/ext_rd_strobe_timer.sv
module ext_rd_strobe_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WAIT_W-1:0] wait_q,
  input  logic              ack,
  output logic              expire
);
  localparam int CNT_W = WAIT_W + 2;

  logic             run;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= (CNT_W'(wait_q) + CNT_W'(1)) << 1;
    end else if (run) begin
      if (cnt == CNT_W'(1)) begin
        if (ack) begin
          run <= 1'b0;
          cnt <= '0;
        end else begin
          cnt <= CNT_W'(2);
        end
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign expire = run && (cnt == CNT_W'(1)) && ack;

  assert_cnt_live_R5: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0));
  assert_ext_step_R5: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == CNT_W'(1) && !ack) |=> (run && cnt == CNT_W'(2)));
endmodule

// File: rtl/ext_rd_capture.sv
module ext_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [DATA_W-1:0] din,
  output logic              valid_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= take;
      if (take) data_q <= din;
    end
  end
endmodule

// File: rtl/ext_rd_seq.sv
module ext_rd_seq
  import ext_rd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [SPACE_W-1:0]  req_space,
  input  logic [WAIT_W-1:0]   wait_cnt,
  output logic                busy,
  output logic [NUM_SEL-1:0]  bus_sel_n,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_rd_n,
  input  logic [DATA_W-1:0]   bus_data_in,
  input  logic                bus_ack,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data
);
  localparam int LO_W = WAIT_W + 3;

  rd_state_e          state;
  logic [NUM_SEL-1:0] sel_hot;
  logic               space_ok;
  logic [WAIT_W-1:0]  wait_q;
  logic               expire;
  logic               accept;

  ext_rd_space_dec #(.SPACE_W(SPACE_W), .NUM_SEL(NUM_SEL)) i_dec (
    .space  (req_space),
    .onehot (sel_hot),
    .valid  (space_ok)
  );

  ext_rd_strobe_timer #(.WAIT_W(WAIT_W)) i_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (state == ST_SETUP),
    .wait_q (wait_q),
    .ack    (bus_ack),
    .expire (expire)
  );

  ext_rd_capture #(.DATA_W(DATA_W)) i_cap (
    .clk     (clk),
    .rst     (rst),
    .take    (expire),
    .din     (bus_data_in),
    .valid_q (rsp_valid),
    .data_q  (rsp_data)
  );

  assign accept = req_valid && (state == ST_IDLE) && space_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_sel_n <= '1;
      bus_addr  <= '0;
      bus_rd_n  <= 1'b1;
      wait_q    <= '0;
      busy      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state     <= ST_SETUP;
          bus_sel_n <= ~sel_hot;
          bus_addr  <= req_addr;
          wait_q    <= wait_cnt;
          busy      <= 1'b1;
        end
        ST_SETUP: begin
          state    <= ST_STROBE;
          bus_rd_n <= 1'b0;
        end
        ST_STROBE: if (expire) begin
          state    <= ST_HOLD;
          bus_rd_n <= 1'b1;
        end
        default: begin
          state     <= ST_IDLE;
          bus_sel_n <= '1;
          bus_addr  <= '0;
          busy      <= 1'b0;
        end
      endcase
    end
  end

  // Run-length counters feeding the timing checks below.
  logic [1:0]      hi_run;
  logic [LO_W-1:0] lo_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= 2'd3;
      lo_run <= '0;
    end else begin
      hi_run <= bus_rd_n ? ((hi_run == 2'd3) ? hi_run : hi_run + 2'd1) : 2'd0;
      lo_run <= !bus_rd_n ? ((&lo_run) ? lo_run : lo_run + LO_W'(1)) : '0;
    end
  end

  assert_one_select_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_sel_n));
  assert_sel_lead_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rd_n) |-> ($past(bus_sel_n) != '1));
  assert_min_width_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rd_n) |-> (lo_run >= ((LO_W'(wait_q) + LO_W'(1)) << 1)));
  assert_done_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $rose(bus_rd_n));
  assert_sel_held_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rd_n) |-> (bus_sel_n != '1));
  assert_sel_release_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rd_n) |=> (bus_sel_n == '1 && bus_addr == '0));
  assert_gap_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rd_n) |-> (hi_run >= 2'd2));
  assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> busy);
  assert_bad_space_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && req_valid && !space_ok) |=> (state == ST_IDLE));
endmodule

// File: tb/test_ext_rd_seq.sv
module test_ext_rd_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [21:0] req_addr = '0;
  logic [2:0]  req_space = '0;
  logic [3:0]  wait_cnt = '0;
  logic        busy;
  logic [5:0]  bus_sel_n;
  logic [21:0] bus_addr;
  logic        bus_rd_n;
  logic [15:0] bus_data_in = 16'hDEAD;
  logic        bus_ack = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_data;

  always #2 clk = ~clk;

  ext_rd_seq i_ext_rd_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_space(req_space), .wait_cnt(wait_cnt), .busy(busy),
    .bus_sel_n(bus_sel_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
    .bus_data_in(bus_data_in), .bus_ack(bus_ack),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  typedef struct {
    logic [21:0] addr;
    logic [2:0]  space;
    int          wt;
    int          ackt;
    logic [15:0] data;
  } item_t;

  item_t q[$];
  item_t cur;
  int n_chk = 0;
  int n_bad = 0;
  int strobes = 0;
  int expected_strobes = 0;
  bit finished = 0;
  bit mon_en = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_width(input int wt, input int a);
    int w = 2 * (wt + 1);
    while (w < a) w += 2;
    return w;
  endfunction

  // Monitor: pops expected items at strobe fall, compares through the cycle.
  bit       prev_rd = 1'b1;
  bit [5:0] prev_sel = '1;
  int       lo = 0;
  int       gap = 0;
  bit       had_cycle = 0;
  bit       trail_pend = 0;
  bit       have_cur = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (trail_pend) begin
        chk(bus_sel_n == 6'h3F && bus_addr == 22'h0, "R7 release",
            {bus_sel_n, bus_addr}, {6'h3F, 22'h0});
        trail_pend = 0;
      end
      if (prev_rd && !bus_rd_n) begin
        strobes++;
        if (q.size() == 0) begin
          chk(0, "R9/R10 unexpected strobe", strobes, expected_strobes);
          have_cur = 0;
        end else begin
          cur = q.pop_front();
          have_cur = 1;
          chk(prev_sel == ~(6'b1 << cur.space), "R3 select lead",
              prev_sel, ~(6'b1 << cur.space));
          chk(bus_sel_n == ~(6'b1 << cur.space), "R2 select code",
              bus_sel_n, ~(6'b1 << cur.space));
          chk(bus_addr == cur.addr, "R3 address", bus_addr, cur.addr);
          if (had_cycle) chk(gap >= 2, "R8 recovery gap", gap, 2);
        end
        lo = 0;
      end
      if (!bus_rd_n) lo++;
      if (!prev_rd && bus_rd_n && have_cur) begin
        chk(lo == exp_width(cur.wt, cur.ackt), "R4/R5 strobe width",
            lo, exp_width(cur.wt, cur.ackt));
        chk(rsp_valid && rsp_data == cur.data, "R6 capture",
            {rsp_valid, rsp_data}, {1'b1, cur.data});
        chk(bus_sel_n == ~(6'b1 << cur.space), "R7 select trail",
            bus_sel_n, ~(6'b1 << cur.space));
        trail_pend = 1;
        had_cycle = 1;
        gap = 0;
      end else if (rsp_valid) begin
        chk(0, "R6 stray done", 1, 0);
      end
      if (bus_rd_n) gap++;
      bus_ack     = bus_rd_n ? 1'b0 : (have_cur && lo >= cur.ackt);
      bus_data_in = (bus_rd_n || !have_cur) ? 16'hDEAD : cur.data;
      prev_rd  = bus_rd_n;
      prev_sel = bus_sel_n;
    end
  end

  // Driver: pushes the expected item, then presents the request.
  task automatic issue(input logic [21:0] a, input logic [2:0] sp,
                       input int wt, input int ackt, input logic [15:0] d);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    it.addr = a; it.space = sp; it.wt = wt; it.ackt = ackt; it.data = d;
    q.push_back(it);
    expected_strobes++;
    req_valid = 1'b1; req_addr = a; req_space = sp; wait_cnt = 4'(wt);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    wait_cnt = 4'hF ^ 4'(wt);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_sel_n == 6'h3F && bus_rd_n && bus_addr == 0 && !busy && !rsp_valid,
        "R1 reset state", {bus_sel_n, bus_rd_n, busy, rsp_valid}, {6'h3F, 3'b100});
    mon_en = 1;

    // R4: zero waitstates, shortest strobe
    issue(22'h000123, 3'd0, 0, 0, 16'h1111); wait_idle();
    // R4: several waitstate counts and each space code (R2)
    issue(22'h3FFFFF, 3'd1, 3, 0, 16'h2222); wait_idle();
    issue(22'h155555, 3'd2, 15, 0, 16'h3333); wait_idle();
    issue(22'h2AAAAA, 3'd3, 1, 0, 16'h4444); wait_idle();
    issue(22'h000F00, 3'd4, 2, 0, 16'h5555); wait_idle();
    issue(22'h00000A, 3'd5, 0, 0, 16'h6666); wait_idle();
    // R5: acknowledge late, rounding to whole peripheral periods
    issue(22'h012345, 3'd0, 0, 5, 16'h7777); wait_idle();
    issue(22'h054321, 3'd4, 1, 9, 16'h8888); wait_idle();
    issue(22'h0ABCDE, 3'd5, 2, 3, 16'h9999); wait_idle();

    // R9: a request presented while busy is ignored
    issue(22'h111111, 3'd2, 7, 0, 16'hAAAA);
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_addr = 22'h222222; req_space = 3'd3;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (8) @(negedge clk);
    chk(strobes == expected_strobes, "R9 held-off request", strobes, expected_strobes);

    // R10: unused space codes start nothing
    for (int c = 6; c < 8; c++) begin
      req_valid = 1'b1; req_space = 3'(c); req_addr = 22'h333333;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (6) @(negedge clk);
      chk(!busy && bus_sel_n == 6'h3F && bus_rd_n, "R10 unused code",
          {busy, bus_sel_n, bus_rd_n}, {1'b0, 6'h3F, 1'b1});
    end
    chk(strobes == expected_strobes, "R10 no strobe", strobes, expected_strobes);

    // R8: back-to-back cycles, gap checked by the monitor
    issue(22'h0C0FFE, 3'd1, 0, 0, 16'hBEEF);
    issue(22'h0FACE0, 3'd3, 0, 0, 16'hCAFE);
    wait_idle();

    chk(strobes == expected_strobes && q.size() == 0, "R6 all responses",
        strobes, expected_strobes);
    finished = 1;
    finish_run();
  end
endmodule